// File: doc/BRIEF.md
# Flag-Setting ALU with Condition Evaluator

This block is the data-processing core of a simple 32-bit execution stage. It has three parts. The first is a combinational unit that adds, subtracts and performs bitwise operations. The second is a four-bit status register that holds the negative, zero, carry and overflow flags. The third is a condition evaluator that decides, from the stored flags, whether the instruction now being presented may take effect.

Each cycle the issuing logic presents one instruction. The instruction is made of an operation code, two operands, a set-flags request, a compare-only marker and a 4-bit condition code. The result and its write-enable appear combinationally in the same cycle. Any flag change takes effect at the next rising clock edge, so the instruction that follows sees the new flags.

A compare is an instruction that sets the flags but keeps no result. An instruction whose condition fails neither writes its result nor alters the flags.

The design holds no sequencer. The only state is the flag register. It moves between two named situations:

- hold: the flags keep their value.
- load: the flags take new values at the next edge. This happens when the condition passes and either a compare or the set-flags request is present.

Top module: `flag_alu`

## Requirements
- R1: Operation code 0 gives A+B and code 1 gives A-B (two's complement, 32-bit wrap). A compare-only instruction always computes A-B, whatever the operation code.
- R2: Operation code 2 gives A AND B, 3 gives A OR B, 4 gives A XOR B, 5 gives A AND NOT B, 6 gives NOT B, and 7 gives zero.
- R3: On an arithmetic flag update, N takes result bit 31 and Z is set when the result is zero. C is the carry out of the addition; after a subtraction C is 1 when no borrow occurs. V is the signed overflow: for an addition, the operands share a sign and the result's sign differs; for a subtraction, the operand signs differ and the result's sign differs from A.
- R4: The flags change only at the clock edge that follows an instruction whose condition passes and which has the set-flags request or the compare-only marker asserted. In every other cycle the flags hold their value.
- R5: A compare-only instruction updates all four flags from A-B and keeps the result write-enable low.
- R6: A flag-setting logical operation (codes 2 to 7) updates N and Z from its result and leaves C and V unchanged.
- R7: Condition pass follows the stored flags:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z&(N==V)
  - 13: Z|(N!=V)
  - 14 and 15: always.
- R8: When the condition fails, the write-enable is low and the flags keep their value, even if the set-flags request or the compare-only marker is asserted.
- R9: After reset all four flags are zero.
- R10: The result write-enable is high exactly when the condition passes and the compare-only marker is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 3 | Operation selector (R1, R2) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| set_flags | input | 1 | Request a flag update from this instruction |
| cmp_only | input | 1 | Compare: subtract, set flags, discard the result |
| cond_code | input | 4 | Condition checked against the stored flags |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result write-enable |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |
| cond_pass | output | 1 | Condition evaluates true |

## Verification
The assertions assume that every input is stable and known by each rising clock edge, so that the flag update depends only on the values sampled there. They also assume that reset is released synchronously to the clock.

The bench changes the inputs only on falling edges and holds each instruction for a full cycle. It checks the combinational outputs first and the flags after the following rising edge. Its reference model keeps its own copy of the flags. With that copy, each sweep of condition codes is run against flag states that the bench itself has built with compares.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_ANDN = 3'd5,
        OP_NOTB = 3'd6,
        OP_ZERO = 3'd7
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_AX = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic {
        FL_HOLD = 1'b0,
        FL_LOAD = 1'b1
    } flag_act_e;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import flag_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output nzcv_t        raw_flags,
    output logic         is_arith
);
    localparam int MSB = W - 1;

    logic         sub_sel;
    logic [W-1:0] b_eff;
    logic [W:0]   sum_ext;

    always_comb begin
        sub_sel = (op == OP_SUB);
        b_eff   = sub_sel ? ~b : b;
        sum_ext = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_sel};
    end

    always_comb begin
        is_arith = 1'b0;
        unique case (op)
            OP_ADD:  begin res = sum_ext[W-1:0]; is_arith = 1'b1; end
            OP_SUB:  begin res = sum_ext[W-1:0]; is_arith = 1'b1; end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_ANDN: res = a & ~b;
            OP_NOTB: res = ~b;
            OP_ZERO: res = '0;
            default: res = '0;
        endcase
    end

    // Overflow: operand signs agree (after B inversion for subtract)
    // and the result sign departs from A.
    always_comb begin
        raw_flags.n = res[MSB];
        raw_flags.z = (res == '0);
        raw_flags.c = sum_ext[W];
        raw_flags.v = (a[MSB] == b_eff[MSB]) && (res[MSB] != a[MSB]);
    end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import flag_alu_pkg::*;
(
    input  cond_e cond,
    input  nzcv_t fl,
    output logic  pass
);
    always_comb begin
        unique case (cond)
            CC_EQ:   pass = fl.z;
            CC_NE:   pass = !fl.z;
            CC_CS:   pass = fl.c;
            CC_CC:   pass = !fl.c;
            CC_MI:   pass = fl.n;
            CC_PL:   pass = !fl.n;
            CC_VS:   pass = fl.v;
            CC_VC:   pass = !fl.v;
            CC_HI:   pass = fl.c && !fl.z;
            CC_LS:   pass = !fl.c || fl.z;
            CC_GE:   pass = (fl.n == fl.v);
            CC_LT:   pass = (fl.n != fl.v);
            CC_GT:   pass = !fl.z && (fl.n == fl.v);
            CC_LE:   pass = fl.z || (fl.n != fl.v);
            CC_AL:   pass = 1'b1;
            CC_AX:   pass = 1'b1;
            default: pass = 1'b1;
        endcase
    end
endmodule

// File: rtl/flag_store.sv
module flag_store
    import flag_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd_en,
    input  logic  arith,
    input  nzcv_t new_fl,
    output nzcv_t cur_fl
);
    flag_act_e act;
    nzcv_t     nxt_fl;

    always_comb begin
        act    = upd_en ? FL_LOAD : FL_HOLD;
        nxt_fl = cur_fl;
        unique case (act)
            FL_LOAD: begin
                nxt_fl.n = new_fl.n;
                nxt_fl.z = new_fl.z;
                if (arith) begin
                    nxt_fl.c = new_fl.c;
                    nxt_fl.v = new_fl.v;
                end
            end
            FL_HOLD: nxt_fl = cur_fl;
            default: nxt_fl = cur_fl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_fl <= '0;
        else        cur_fl <= nxt_fl;
    end

    // R4: no update request, no change
    a_r4_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(cur_fl));
    // R6: logical update keeps C and V
    a_r6_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !arith) |=> ($stable(cur_fl.c) && $stable(cur_fl.v)));
    // R3: arithmetic update copies all four flags
    a_r3_arith_load: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && arith) |=> (cur_fl == $past(new_fl)));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         set_flags,
    input  logic         cmp_only,
    input  logic [3:0]   cond_code,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v,
    output logic         cond_pass
);
    alu_op_e eff_op;
    nzcv_t   raw_fl;
    nzcv_t   cur_fl;
    logic    arith;
    logic    upd_en;

    always_comb eff_op = cmp_only ? OP_SUB : alu_op_e'(op_code);

    alu_datapath #(.W(W)) u_dp (
        .op        (eff_op),
        .a         (opnd_a),
        .b         (opnd_b),
        .res       (result),
        .raw_flags (raw_fl),
        .is_arith  (arith)
    );

    cond_eval u_cond (
        .cond (cond_e'(cond_code)),
        .fl   (cur_fl),
        .pass (cond_pass)
    );

    always_comb begin
        result_we = cond_pass && !cmp_only;
        upd_en    = cond_pass && (set_flags || cmp_only);
    end

    flag_store u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_en (upd_en),
        .arith  (arith),
        .new_fl (raw_fl),
        .cur_fl (cur_fl)
    );

    always_comb begin
        flag_n = cur_fl.n;
        flag_z = cur_fl.z;
        flag_c = cur_fl.c;
        flag_v = cur_fl.v;
    end

    // R5: compare never writes
    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_only |-> !result_we);
    // R8: failed condition: no write, flags stay
    a_r8_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pass |=> ($stable({flag_n, flag_z, flag_c, flag_v}) && 1'b1));
    a_r8_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pass |-> !result_we);
    // R7: always-conditions pass
    a_r7_always_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code[3:1] == 3'b111) |-> cond_pass);
endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        set_flags = 1'b0, cmp_only = 1'b0;
    logic [3:0]  cond_code = 4'd14;
    logic [31:0] result;
    logic        result_we, flag_n, flag_z, flag_c, flag_v, cond_pass;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] mfl = 4'b0000; // {N,Z,C,V}

    always #5 clk = ~clk;

    flag_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .set_flags(set_flags), .cmp_only(cmp_only),
        .cond_code(cond_code), .result(result), .result_we(result_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .cond_pass(cond_pass)
    );

    function automatic logic m_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0: return z;        4'd1: return !z;
            4'd2: return cy;       4'd3: return !cy;
            4'd4: return n;        4'd5: return !n;
            4'd6: return v;        4'd7: return !v;
            4'd8: return cy & !z;  4'd9: return !cy | z;
            4'd10: return n == v;  4'd11: return n != v;
            4'd12: return !z & (n == v);
            4'd13: return z | (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one instruction and check it against the model
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sf, input logic cmp, input logic [3:0] cc, input string req);
        logic [2:0]  eop;
        logic [32:0] s;
        logic [31:0] r;
        logic        ps, c_new, v_new;
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; set_flags = sf; cmp_only = cmp; cond_code = cc;
        eop = cmp ? 3'd1 : op;
        c_new = 1'b0; v_new = 1'b0;
        case (eop)
            3'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[31:0]; c_new = s[32];
                        v_new = (a[31] == b[31]) && (r[31] != a[31]); end
            3'd1: begin s = {1'b0, a} + {1'b0, ~b} + 33'd1; r = s[31:0]; c_new = s[32];
                        v_new = (a[31] != b[31]) && (r[31] != a[31]); end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = a & ~b;
            3'd6: r = ~b;
            default: r = '0;
        endcase
        ps = m_pass(cc, mfl);
        #1;
        chk({req, " result"}, result, r);
        chk({req, " R7 pass"}, {31'd0, cond_pass}, {31'd0, ps});
        chk({req, " R10 we"}, {31'd0, result_we}, {31'd0, ps && !cmp});
        if (ps && (sf || cmp)) begin
            if (eop <= 3'd1) mfl = {r[31], r == 0, c_new, v_new};
            else             mfl = {r[31], r == 0, mfl[1], mfl[0]};
        end
        @(posedge clk); #1;
        chk({req, " R4 flags"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, mfl});
    endtask

    task automatic t_reset;
        chk("R9 reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    endtask

    task automatic t_arith;
        issue(3'd0, 32'd5, 32'd7, 1'b0, 1'b0, 4'd14, "R1 add");
        issue(3'd1, 32'd5, 32'd7, 1'b0, 1'b0, 4'd14, "R1 sub");
        issue(3'd0, 32'h7FFFFFFF, 32'd1, 1'b1, 1'b0, 4'd14, "R3 add ovf");
        chk("R3 V on add", {31'd0, flag_v}, 32'd1);
        issue(3'd0, 32'hFFFFFFFF, 32'd1, 1'b1, 1'b0, 4'd14, "R3 add carry zero");
        chk("R3 C,Z", {30'd0, flag_c, flag_z}, 32'd3);
        issue(3'd1, 32'h80000000, 32'd1, 1'b1, 1'b0, 4'd14, "R3 sub ovf");
        issue(3'd1, 32'd9, 32'd9, 1'b1, 1'b0, 4'd14, "R3 sub equal");
    endtask

    task automatic t_logic;
        issue(3'd1, 32'd1, 32'd2, 1'b1, 1'b0, 4'd14, "R3 borrow setup"); // N=1,C=0
        issue(3'd0, 32'h7FFFFFFF, 32'd1, 1'b1, 1'b0, 4'd14, "R3 set V");  // V=1
        issue(3'd2, 32'hF234012F, 32'h000000FF, 1'b0, 1'b0, 4'd14, "R2 and");
        issue(3'd3, 32'hF2340000, 32'h000012BC, 1'b0, 1'b0, 4'd14, "R2 or");
        issue(3'd4, 32'hA5A5A5A5, 32'hFFFF0000, 1'b0, 1'b0, 4'd14, "R2 xor");
        issue(3'd5, 32'hF234012F, 32'hFFFFFF00, 1'b1, 1'b0, 4'd14, "R6 andn flag");
        chk("R6 V kept", {31'd0, flag_v}, 32'd1);
        issue(3'd6, 32'h0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd14, "R6 notb zero");
        chk("R6 Z set", {31'd0, flag_z}, 32'd1);
        issue(3'd7, 32'h1234, 32'h5678, 1'b1, 1'b0, 4'd14, "R2 zero op");
    endtask

    task automatic t_compare;
        issue(3'd0, 32'd17, 32'd23, 1'b0, 1'b1, 4'd14, "R5 cmp 17-23");
        chk("R5 NZCV", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'b1000);
        issue(3'd4, 32'd23, 32'd17, 1'b0, 1'b1, 4'd14, "R5 cmp 23-17");
        chk("R5 no borrow C", {31'd0, flag_c}, 32'd1);
    endtask

    task automatic t_cond_sweep(input logic [31:0] a, input logic [31:0] b);
        issue(3'd1, a, b, 1'b0, 1'b1, 4'd14, "R5 sweep setup");
        for (int c = 0; c < 16; c++)
            issue(3'd0, 32'd3, 32'd4, 1'b0, 1'b0, c[3:0], "R7 cond");
    endtask

    task automatic t_cond_fail;
        issue(3'd1, 32'd1, 32'd1, 1'b0, 1'b1, 4'd14, "R8 setup Z");
        issue(3'd1, 32'd1, 32'd5, 1'b1, 1'b0, 4'd1, "R8 NE fails sf");
        issue(3'd1, 32'd1, 32'd5, 1'b0, 1'b1, 4'd1, "R8 NE fails cmp");
        chk("R8 flags kept", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'b0110);
        issue(3'd0, 32'd1, 32'd5, 1'b1, 1'b0, 4'd0, "R8 EQ passes");
    endtask

    initial begin
        #1;
        t_reset;
        #24 rst_n = 1'b1;
        t_arith;
        t_logic;
        t_compare;
        t_cond_sweep(32'd17, 32'd23);
        t_cond_sweep(32'd23, 32'd17);
        t_cond_sweep(32'd4, 32'd4);
        t_cond_sweep(32'h80000000, 32'd1);
        t_cond_sweep(32'h7FFFFFFF, 32'hFFFFFFFF);
        t_cond_fail;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule